// File: doc/BRIEF.md
# NOR Flash Program and Erase Sequencer

This block sits between a simple request port and the parallel bus of a NOR flash device. It carries out byte programming, sector erase and whole-device erase on behalf of the requester. A request names the operation, a 19-bit target address and a data byte. The sequencer then issues the whole command sequence on the flash bus, including the unlock writes that open command mode. Every write cycle is timed by parameters counted in clock cycles.

Once the final command write has completed, the sequencer reads the device status repeatedly. It ends the operation when the toggling status bit holds the same value in two consecutive reads. A per-operation cycle budget bounds this wait. If the budget runs out, the requester gets an error pulse in place of a done pulse.

While an operation is running, the request port is closed. Any request that arrives in that time is dropped.

Top module: `nor_cmd_seq`

## Requirements
- R1: Out of reset, `ready` is high, `flash_ce_n`, `flash_we_n` and `flash_oe_n` are high, `flash_dq_oe` is low, and `done` and `error` are low.
- R2: During every write cycle, `flash_oe_n` stays high. `flash_ce_n` and `flash_we_n` go low together for exactly `T_WL` clock cycles. Address and write data hold steady throughout that low time.
- R3: A request with operation code 0 (byte program) produces exactly four writes, as address/data pairs: 05555h/AAh, 02AAAh/55h, 05555h/A0h, and then the request address with the request data byte.
- R4: A request with operation code 1 (sector erase) produces exactly six writes: 05555h/AAh, 02AAAh/55h, 05555h/80h, 05555h/AAh, 02AAAh/55h, and then the request address with 30h.
- R5: A request with operation code 2 (whole-device erase) produces the same first five writes as R4, and then a sixth write of 10h to 05555h. On every unlock write, address bits 18 down to 15 are driven as zero.
- R6: After the final write, the sequencer issues status reads. A status read drives `flash_ce_n` and `flash_oe_n` low and `flash_dq_oe` low. When bit 6 of two consecutive reads is equal, `done` pulses for one cycle and `ready` is high in that same cycle. `done` never comes before the device has stopped toggling.
- R7: Polling time is limited to `LIM_PROG`, `LIM_SECT` or `LIM_CHIP` clock cycles, depending on the operation. If toggling continues past that limit, `error` pulses once and `done` does not pulse. The error arrives no earlier than the limit and within one read cycle after it.
- R8: While `ready` is low, requests are ignored. Operation code 3 is also ignored: it causes no bus activity, and `ready` stays high.
- R9: `done` and `error` are never high together, and each lasts exactly one cycle.
- R10: Once a request is accepted, `ready` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while ready is high |
| req_op | input | 2 | 0 program, 1 sector erase, 2 whole-device erase, 3 ignored |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | DW | Byte to program |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle timeout pulse |
| flash_addr | output | AW | Flash address bus |
| flash_dq_out | output | DW | Flash write data |
| flash_dq_oe | output | 1 | Drive enable for the flash data bus |
| flash_dq_in | input | DW | Flash read data |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |

## Verification
The bench builds the sequencer with `T_SETUP`=1, `T_WL`=2, `T_RD`=2 and `T_WH`=2. The polling limits are set to 150, 300 and 400 cycles, which shrinks the millisecond-scale defaults to a scale where a device model that stays busy for 1000 cycles runs into the timeout within a short run. Randomized busy lengths between 3 and 100 cycles make completion fall at every phase of the read cycle. Among them are busy periods that end before the first status read.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_CHIP = 2'd2,
      OP_RSVD = 2'd3
   } nfs_op_e;

   typedef struct packed {
      logic        take_addr;
      logic        take_data;
      logic [14:0] unl_addr;
      logic [7:0]  code;
   } nfs_step_t;

   localparam logic [14:0] UNL_A = 15'h5555;
   localparam logic [14:0] UNL_B = 15'h2AAA;

   function automatic logic [2:0] seq_last(nfs_op_e op);
      return (op == OP_PROG) ? 3'd3 : 3'd5;
   endfunction

   function automatic nfs_step_t seq_step(nfs_op_e op, logic [2:0] idx);
      nfs_step_t s;
      s = '0;
      case (idx)
         3'd0: begin s.unl_addr = UNL_A; s.code = 8'hAA; end
         3'd1: begin s.unl_addr = UNL_B; s.code = 8'h55; end
         3'd2: begin
            s.unl_addr = UNL_A;
            s.code     = (op == OP_PROG) ? 8'hA0 : 8'h80;
         end
         3'd3: begin
            if (op == OP_PROG) begin
               s.take_addr = 1'b1;
               s.take_data = 1'b1;
            end else begin
               s.unl_addr = UNL_A;
               s.code     = 8'hAA;
            end
         end
         3'd4: begin s.unl_addr = UNL_B; s.code = 8'h55; end
         default: begin
            if (op == OP_CHIP) begin
               s.unl_addr = UNL_A;
               s.code     = 8'h10;
            end else begin
               s.take_addr = 1'b1;
               s.code      = 8'h30;
            end
         end
      endcase
      return s;
   endfunction

endpackage

// File: rtl/nfs_bus_phy.sv
module nfs_bus_phy #(
   parameter int unsigned AW      = 19,
   parameter int unsigned DW      = 8,
   parameter int unsigned T_SETUP = 1,
   parameter int unsigned T_WL    = 3,
   parameter int unsigned T_RD    = 3,
   parameter int unsigned T_WH    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_read,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] wdata_in,
   output logic          fin,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] flash_addr,
   output logic [DW-1:0] flash_dq_out,
   output logic          flash_dq_oe,
   input  logic [DW-1:0] flash_dq_in,
   output logic          flash_ce_n,
   output logic          flash_oe_n,
   output logic          flash_we_n
);

   localparam int unsigned TA   = (T_SETUP > T_WL) ? T_SETUP : T_WL;
   localparam int unsigned TB   = (T_RD > T_WH) ? T_RD : T_WH;
   localparam int unsigned TMAX = (TA > TB) ? TA : TB;
   localparam int unsigned CW   = $clog2(TMAX + 1);

   generate
      if (T_SETUP < 1 || T_WL < 1 || T_RD < 1 || T_WH < 1) begin : g_bad_timing
         $error("nfs_bus_phy: every phase length must be at least one cycle");
      end
   endgenerate

   typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_REC} ph_e;

   ph_e           ph;
   logic [CW-1:0] cnt;
   logic          rd_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         cnt     <= '0;
         rd_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
         fin     <= 1'b0;
      end else begin
         fin <= 1'b0;
         case (ph)
            PH_IDLE: begin
               if (start) begin
                  addr_q  <= addr_in;
                  wdata_q <= wdata_in;
                  rd_q    <= is_read;
                  cnt     <= CW'(T_SETUP - 1);
                  ph      <= PH_SETUP;
               end
            end
            PH_SETUP: begin
               if (cnt == '0) begin
                  ph  <= PH_LOW;
                  cnt <= rd_q ? CW'(T_RD - 1) : CW'(T_WL - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_LOW: begin
               if (cnt == '0) begin
                  ph  <= PH_REC;
                  cnt <= CW'(T_WH - 1);
                  if (rd_q) rdata <= flash_dq_in;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               if (cnt == '0) begin
                  ph  <= PH_IDLE;
                  fin <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         endcase
      end
   end

   assign flash_addr   = addr_q;
   assign flash_dq_out = wdata_q;
   assign flash_dq_oe  = (ph != PH_IDLE) && !rd_q;
   assign flash_ce_n   = !(ph == PH_LOW);
   assign flash_we_n   = !(ph == PH_LOW && !rd_q);
   assign flash_oe_n   = !(ph == PH_LOW && rd_q);

   assert_write_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_we_n |-> (flash_oe_n && !flash_ce_n && flash_dq_oe));

   assert_hold_during_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

   assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_oe_n |-> (!flash_dq_oe && flash_we_n));

endmodule

// File: rtl/nfs_poll_timer.sv
module nfs_poll_timer
   import nfs_pkg::*;
#(
   parameter int unsigned LIM_PROG = 6250,
   parameter int unsigned LIM_SECT = 3125000,
   parameter int unsigned LIM_CHIP = 12500000
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  nfs_op_e op,
   input  logic    run,
   output logic    expired
);

   localparam int unsigned LA   = (LIM_PROG > LIM_SECT) ? LIM_PROG : LIM_SECT;
   localparam int unsigned LMAX = (LA > LIM_CHIP) ? LA : LIM_CHIP;
   localparam int unsigned CW   = $clog2(LMAX + 1);

   generate
      if (LIM_PROG < 1 || LIM_SECT < 1 || LIM_CHIP < 1) begin : g_bad_limit
         $error("nfs_poll_timer: polling limits must be non-zero");
      end
   endgenerate

   function automatic logic [CW-1:0] lim_of(nfs_op_e o);
      case (o)
         OP_PROG: return CW'(LIM_PROG);
         OP_SECT: return CW'(LIM_SECT);
         default: return CW'(LIM_CHIP);
      endcase
   endfunction

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= lim_of(op);
      end else if (run && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = run && (cnt == '0);

   assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !expired);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nfs_pkg::*;
#(
   parameter int unsigned AW       = 19,
   parameter int unsigned DW       = 8,
   parameter int unsigned TOG_BIT  = 6,
   parameter int unsigned T_SETUP  = 1,
   parameter int unsigned T_WL     = 3,
   parameter int unsigned T_RD     = 3,
   parameter int unsigned T_WH     = 2,
   parameter int unsigned LIM_PROG = 6250,
   parameter int unsigned LIM_SECT = 3125000,
   parameter int unsigned LIM_CHIP = 12500000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   output logic          ready,
   output logic          done,
   output logic          error,
   output logic [AW-1:0] flash_addr,
   output logic [DW-1:0] flash_dq_out,
   output logic          flash_dq_oe,
   input  logic [DW-1:0] flash_dq_in,
   output logic          flash_ce_n,
   output logic          flash_oe_n,
   output logic          flash_we_n
);

   generate
      if (AW < 15 || DW < 8 || TOG_BIT >= DW) begin : g_bad_width
         $error("nor_cmd_seq: needs AW >= 15, DW >= 8 and TOG_BIT inside DW");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;

   st_e           st;
   nfs_op_e       op_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [2:0]    idx_q;
   logic          polling_q;
   logic          prev_q;
   logic          have_prev_q;

   nfs_step_t     step;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          phy_fin;
   logic [DW-1:0] phy_rdata;
   logic          tmr_load;
   logic          tmr_expired;
   logic          last_write;
   logic          tog_now;
   logic          unused_rd_bits;

   always_comb step = seq_step(op_q, idx_q);

   assign wr_addr        = step.take_addr ? addr_q : AW'(step.unl_addr);
   assign wr_data        = step.take_data ? data_q : DW'(step.code);
   assign last_write     = (idx_q == seq_last(op_q));
   assign tog_now        = phy_rdata[TOG_BIT];
   assign unused_rd_bits = ^(phy_rdata & ~(DW'(1) << TOG_BIT));
   assign tmr_load       = (st == S_WAIT) && phy_fin && !polling_q && last_write;
   assign ready          = (st == S_IDLE);

   nfs_bus_phy #(
      .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_WL(T_WL), .T_RD(T_RD), .T_WH(T_WH)
   ) u_phy (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (st == S_ISSUE),
      .is_read      (polling_q),
      .addr_in      (polling_q ? addr_q : wr_addr),
      .wdata_in     (wr_data),
      .fin          (phy_fin),
      .rdata        (phy_rdata),
      .flash_addr   (flash_addr),
      .flash_dq_out (flash_dq_out),
      .flash_dq_oe  (flash_dq_oe),
      .flash_dq_in  (flash_dq_in),
      .flash_ce_n   (flash_ce_n),
      .flash_oe_n   (flash_oe_n),
      .flash_we_n   (flash_we_n)
   );

   nfs_poll_timer #(
      .LIM_PROG(LIM_PROG), .LIM_SECT(LIM_SECT), .LIM_CHIP(LIM_CHIP)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .op      (op_q),
      .run     (polling_q && st != S_IDLE),
      .expired (tmr_expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         op_q        <= OP_PROG;
         addr_q      <= '0;
         data_q      <= '0;
         idx_q       <= '0;
         polling_q   <= 1'b0;
         prev_q      <= 1'b0;
         have_prev_q <= 1'b0;
         done        <= 1'b0;
         error       <= 1'b0;
      end else begin
         done  <= 1'b0;
         error <= 1'b0;
         case (st)
            S_IDLE: begin
               if (req_valid && nfs_op_e'(req_op) != OP_RSVD) begin
                  op_q        <= nfs_op_e'(req_op);
                  addr_q      <= req_addr;
                  data_q      <= req_data;
                  idx_q       <= '0;
                  polling_q   <= 1'b0;
                  have_prev_q <= 1'b0;
                  st          <= S_ISSUE;
               end
            end
            S_ISSUE: st <= S_WAIT;
            default: begin
               if (phy_fin) begin
                  if (!polling_q) begin
                     if (last_write) polling_q <= 1'b1;
                     else            idx_q     <= idx_q + 1'b1;
                     st <= S_ISSUE;
                  end else if (have_prev_q && tog_now == prev_q) begin
                     done <= 1'b1;
                     st   <= S_IDLE;
                  end else if (tmr_expired) begin
                     error <= 1'b1;
                     st    <= S_IDLE;
                  end else begin
                     prev_q      <= tog_now;
                     have_prev_q <= 1'b1;
                     st          <= S_ISSUE;
                  end
               end
            end
         endcase
      end
   end

   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, error}));

   assert_done_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);

   assert_error_after_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> $past(tmr_expired));

   assert_reserved_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid && req_op == 2'd3) |=> (ready && flash_ce_n));

   assert_accept_drops_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid && req_op != 2'd3) |=> !ready);

endmodule

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;

   localparam int T_SETUP  = 1;
   localparam int T_WL     = 2;
   localparam int T_RD     = 2;
   localparam int T_WH     = 2;
   localparam int LIM_PROG = 150;
   localparam int LIM_SECT = 300;
   localparam int LIM_CHIP = 400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd0;
   logic [18:0] req_addr = '0;
   logic [7:0]  req_data = '0;
   logic        ready, done, error;
   logic [18:0] flash_addr;
   logic [7:0]  flash_dq_out;
   logic        flash_dq_oe;
   logic [7:0]  flash_dq_in;
   logic        flash_ce_n, flash_oe_n, flash_we_n;

   always #4 clk = ~clk;

   nor_cmd_seq #(
      .T_SETUP(T_SETUP), .T_WL(T_WL), .T_RD(T_RD), .T_WH(T_WH),
      .LIM_PROG(LIM_PROG), .LIM_SECT(LIM_SECT), .LIM_CHIP(LIM_CHIP)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .ready(ready), .done(done),
      .error(error), .flash_addr(flash_addr), .flash_dq_out(flash_dq_out),
      .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in),
      .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // device model state
   int          cyc = 0;
   int          busy_left = 0;
   int          busy_cfg = 0;
   int          exp_len = 0;
   int          nw = 0;
   int          wl_cnt = 0;
   int          done_cnt = 0;
   int          err_cnt = 0;
   int          done_busy = 0;
   int          wend_cyc = 0;
   int          evt_cyc = 0;
   logic        tog = 1'b0;
   logic        prev_we = 1'b1;
   logic        prev_oe = 1'b1;
   logic        prev_done = 1'b0;
   logic        prev_err = 1'b0;
   logic [18:0] lat_a;
   logic [7:0]  lat_d;
   logic [18:0] log_a [16];
   logic [7:0]  log_d [16];

   assign flash_dq_in = {1'b0, tog, 6'b0};

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!flash_we_n) begin
            if (prev_we) begin
               wl_cnt = 1;
               lat_a  = flash_addr;
               lat_d  = flash_dq_out;
            end else begin
               wl_cnt++;
               check(flash_addr == lat_a && flash_dq_out == lat_d, "R2 hold", flash_addr, lat_a);
            end
            check(flash_oe_n == 1'b1, "R2 oe high", flash_oe_n, 1);
         end
         if (flash_we_n && !prev_we) begin
            check(wl_cnt == T_WL, "R2 low width", wl_cnt, T_WL);
            if (nw < 16) begin
               log_a[nw] = lat_a;
               log_d[nw] = lat_d;
            end
            nw++;
            if (nw == exp_len) begin
               busy_left = busy_cfg;
               wend_cyc  = cyc;
            end
         end
         if (!flash_oe_n && prev_oe && busy_left > 0) tog = ~tog;
         if (done) begin
            done_cnt++;
            done_busy = busy_left;
            evt_cyc   = cyc;
         end
         if (error) begin
            err_cnt++;
            evt_cyc = cyc;
         end
         check(!(done && error), "R9 both", {done, error}, 0);
         if ((done && prev_done) || (error && prev_err))
            check(1'b0, "R9 width", 2, 1);
         if (busy_left > 0) busy_left--;
         prev_we   = flash_we_n;
         prev_oe   = flash_oe_n;
         prev_done = done;
         prev_err  = error;
      end
   end

   function automatic logic [18:0] e_addr(int op, int i, logic [18:0] a);
      if (op == 0) return (i == 3) ? a : ((i == 1) ? 19'h02AAA : 19'h05555);
      if (i == 1 || i == 4) return 19'h02AAA;
      if (i == 5 && op == 1) return a;
      return 19'h05555;
   endfunction

   function automatic logic [7:0] e_data(int op, int i, logic [7:0] d);
      case (i)
         0: return 8'hAA;
         1: return 8'h55;
         2: return (op == 0) ? 8'hA0 : 8'h80;
         3: return (op == 0) ? d : 8'hAA;
         4: return 8'h55;
         default: return (op == 1) ? 8'h30 : 8'h10;
      endcase
   endfunction

   task automatic issue(input int op, input logic [18:0] a, input logic [7:0] d, input int busy);
      while (!ready) @(negedge clk);
      busy_cfg  = busy;
      busy_left = 0;
      exp_len   = (op == 0) ? 4 : 6;
      nw        = 0;
      done_cnt  = 0;
      err_cnt   = 0;
      req_op    = 2'(op);
      req_addr  = a;
      req_data  = d;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(ready == 1'b0, "R10 ready drop", ready, 0);
   endtask

   task automatic finish_tx(input int op, input logic [18:0] a, input logic [7:0] d,
                            input int busy, input bit exp_err);
      string tg;
      int lim;
      tg  = (op == 0) ? "R3" : ((op == 1) ? "R4" : "R5");
      lim = (op == 0) ? LIM_PROG : ((op == 1) ? LIM_SECT : LIM_CHIP);
      for (int k = 0; k < 3000 && done_cnt == 0 && err_cnt == 0; k++) @(negedge clk);
      repeat (3) @(negedge clk);
      check(nw == exp_len, {tg, " write count"}, nw, exp_len);
      for (int i = 0; i < exp_len && i < nw; i++) begin
         check(log_a[i] == e_addr(op, i, a), {tg, " address"}, log_a[i], e_addr(op, i, a));
         check(log_d[i] == e_data(op, i, d), {tg, " data"}, log_d[i], e_data(op, i, d));
      end
      if (!exp_err) begin
         check(done_cnt == 1 && err_cnt == 0, "R6 done once", done_cnt, 1);
         check(done_busy == 0, "R6 done after busy", done_busy, 0);
         check(evt_cyc - wend_cyc <= busy + 40, "R6 latency", evt_cyc - wend_cyc, busy + 40);
      end else begin
         check(err_cnt == 1 && done_cnt == 0, "R7 error once", err_cnt, 1);
         check(evt_cyc - wend_cyc >= lim, "R7 not early", evt_cyc - wend_cyc, lim);
         check(evt_cyc - wend_cyc <= lim + 25, "R7 not late", evt_cyc - wend_cyc, lim + 25);
      end
      check(ready == 1'b1, "R6 ready back", ready, 1);
   endtask

   task automatic run_tx(input int op, input logic [18:0] a, input logic [7:0] d,
                         input int busy, input bit exp_err);
      issue(op, a, d, busy);
      finish_tx(op, a, d, busy, exp_err);
   endtask

   initial begin
      for (int k = 0; k < 150000 && !finished; k++) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'h5EED_0042);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ready == 1'b1, "R1 ready", ready, 1);
      check(flash_ce_n && flash_we_n && flash_oe_n, "R1 strobes",
            {flash_ce_n, flash_we_n, flash_oe_n}, 7);
      check(flash_dq_oe == 1'b0, "R1 dq_oe", flash_dq_oe, 0);
      check(!done && !error, "R1 flags", {done, error}, 0);

      // directed: R3, R4, R5
      run_tx(0, 19'h7FFFF, 8'h5A, 20, 0);
      run_tx(1, 19'h12345, 8'h00, 50, 0);
      run_tx(2, 19'h6ABCD, 8'hFF, 100, 0);
      run_tx(0, 19'h00000, 8'hC3, 3, 0);

      // R8 reserved opcode
      exp_len = 4; nw = 0; done_cnt = 0; err_cnt = 0;
      req_op = 2'd3; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(ready == 1'b1, "R8 reserved ready", ready, 1);
      repeat (20) @(negedge clk);
      check(nw == 0 && flash_ce_n, "R8 reserved no writes", nw, 0);
      check(done_cnt == 0 && err_cnt == 0, "R8 reserved no flags", done_cnt, 0);

      // R8 request during busy is dropped
      issue(0, 19'h0AAAA, 8'h11, 60);
      repeat (10) @(negedge clk);
      req_op = 2'd2; req_addr = 19'h11111; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      finish_tx(0, 19'h0AAAA, 8'h11, 60, 0);
      repeat (30) @(negedge clk);
      check(nw == 4 && done_cnt == 1, "R8 busy request dropped", nw, 4);

      // R7 timeout
      run_tx(0, 19'h01234, 8'h77, 1000, 1);
      busy_left = 0;

      // random mix
      for (int t = 0; t < 10; t++) begin
         int op;
         op = int'($urandom % 3);
         run_tx(op, 19'($urandom), 8'($urandom), 3 + int'($urandom % 98), 0);
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule